// File: doc/BRIEF.md
# Pipelined Floating-Point Reciprocal Unit

This block returns 1/x for single-precision (binary32) operands. It accepts one operand per clock and produces one result per clock after a fixed delay. Each operand is split by integer logic into a 9-bit field (sign and biased exponent) and a 23-bit fraction. The fraction, with its hidden one restored, forms a mantissa y in [1,2).

The 9-bit field indexes a 512-entry table. That table returns the sign and the power-of-two scale of the result. The top 8 fraction bits index a 256-entry table, which gives a first guess for 1/y. The guess is improved twice with the Newton step x' = x·(2 − y·x) in fixed point. Each step is split across two pipeline stages. The refined value lies in (0.5, 1]. It is rounded to 24 bits and recombined with the power-of-two scale from the exponent table, with a one-step exponent adjustment when the rounded value falls below one.

Zero and denormal operands, infinities and NaNs bypass the arithmetic. Results too small for a normal number are flushed to a signed zero. The unit is meant to be dropped into a streaming datapath that needs division: the divisor goes through this block and the quotient is formed by a multiply downstream.

Top module: `fp_recip_pipe`

## Requirements
- R1: For every input with biased exponent 1..254 the result is finite (exponent field not 255). Its sign-plus-magnitude pattern differs by at most 1 in bits [30:0] from the correctly rounded reciprocal. With mantissa M = 2^23 + fraction, the correctly rounded value has fraction round(2^47/M) mod 2^23 and biased exponent 253 − e.
- R2: An input whose fraction is zero (an exact power of two, biased exponent e) gives exactly biased exponent 254 − e and a zero fraction, as long as that exponent is at least 1.
- R3: The sign bit (bit 31) of every non-NaN result equals the sign bit of its input.
- R4: An input with biased exponent 0 (zero or denormal, the latter flushed to zero) gives infinity of the same sign: {sign, 8'hFF, 23'h0}.
- R5: An infinite input (exponent 255, fraction 0) gives a zero of the same sign: {sign, 31'h0}.
- R6: A NaN input (exponent 255, nonzero fraction, either sign, quiet or signalling) gives the quiet NaN 32'h7FC00000.
- R7: When the result's biased exponent would be 0 or below, the output is {sign, 31'h0}. Examples are an input exponent of 254, or an exponent of 253 with a nonzero fraction.
- R8: out_valid equals in_valid delayed by exactly 6 clock cycles (2 per Newton step plus one decode stage and one output stage).
- R9: Operands may arrive on every cycle or with any pattern of idle cycles. Each valid input yields exactly one valid output, in input order, with no extra valid outputs.
- R10: While rst_n is low, and after it rises until the first operand has passed through, out_valid is 0. A reset in mid-stream discards every operand in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand on in_data is valid this cycle |
| in_data | input | 32 | binary32 operand |
| out_valid | output | 1 | Result on out_data is valid this cycle |
| out_data | output | 32 | binary32 reciprocal |

## Verification
The hardest cases to reach from the ports sit where the rounded mantissa reciprocal crosses 1.0 and meets the exponent limits. A mantissa of exactly one refines to just below one and must round up into an exponent increment. Near the bottom of the exponent range, that same choice decides between a normal result and a flushed zero. The stimulus reaches these cases with directed operands whose fractions sit at the two ends of the mantissa range (0, 1, 2, all-ones). These fractions are combined with exponents 1, 126, 127, 252, 253 and 254, and a few thousand pseudo-random normal operands follow, checked against an integer long-division model. Special operands are interleaved in a back-to-back stream so that they share the pipeline with normal operands.

// File: rtl/fp_recip_pkg.sv
package fp_recip_pkg;

    localparam int FP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;

    localparam logic [FP_W-1:0] CANON_QNAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } opclass_e;

    // sideband carried alongside the mantissa refinement
    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] ebase;   // biased exponent of the result when mantissa recip == 1
        opclass_e         cls;
    } opmeta_t;

    // first guess of 1/y for the bucket centred at 1 + (idx + 0.5) / 2^idx_w
    function automatic longint seed_value(input int idx, input int idx_w, input int seed_w);
        longint num;
        longint den;
        num = longint'(1) << (seed_w + idx_w + 1);
        den = (longint'(1) << (idx_w + 1)) + 2 * longint'(idx) + 1;
        return num / den;
    endfunction

    // {sign, scale exponent} for a {sign, biased exponent} index
    function automatic int exp_entry(input int idx, input int exp_w);
        int top;
        int e;
        int sgn;
        top = (1 << exp_w) - 2;
        e   = idx % (1 << exp_w);
        sgn = idx >> exp_w;
        if (e >= 1 && e <= top) begin
            return (sgn << exp_w) | (top - e);
        end
        return sgn << exp_w;
    endfunction

endpackage

// File: rtl/fp_recip_exp_rom.sv
module fp_recip_exp_rom #(
    parameter int EXP_W = 8
) (
    input  logic [EXP_W:0] idx,
    output logic [EXP_W:0] entry
);
    localparam int DEPTH = 1 << (EXP_W + 1);

    logic [EXP_W:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign rom[g] = (EXP_W + 1)'(fp_recip_pkg::exp_entry(g, EXP_W));
    end

    assign entry = rom[idx];

endmodule

// File: rtl/fp_recip_seed_rom.sv
module fp_recip_seed_rom #(
    parameter int IDX_W  = 8,
    parameter int SEED_W = 16
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [SEED_W-1:0] seed
);
    localparam int DEPTH = 1 << IDX_W;

    logic [SEED_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign rom[g] = SEED_W'(fp_recip_pkg::seed_value(g, IDX_W, SEED_W));
    end

    assign seed = rom[idx];

endmodule

// File: rtl/fp_recip_nr_step.sv
// One Newton refinement x' = x * (2 - y*x), split over two registered stages.
// y is Q1.(YW-1), x and x' are Q0.FW.
module fp_recip_nr_step #(
    parameter int YW = 24,
    parameter int FW = 32,
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [YW-1:0] in_y,
    input  logic [FW-1:0] in_x,
    input  logic [PW-1:0] in_pay,
    output logic          out_valid,
    output logic [YW-1:0] out_y,
    output logic [FW-1:0] out_x,
    output logic [PW-1:0] out_pay
);
    localparam int PROD_W = YW + FW;
    localparam int MUL2_W = 2 * FW;

    typedef struct packed {
        logic          a_v;
        logic [YW-1:0] a_y;
        logic [FW-1:0] a_x;
        logic [FW-1:0] a_t;     // 2 - y*x, Q1.(FW-1)
        logic [PW-1:0] a_p;
        logic          b_v;
        logic [YW-1:0] b_y;
        logic [FW-1:0] b_x;
        logic [PW-1:0] b_p;
    } step_t;

    step_t st_d, st_q;

    logic [PROD_W-1:0] yx;
    logic [PROD_W:0]   two_minus;
    logic [MUL2_W-1:0] xt;

    always_comb begin
        st_d = st_q;

        // stage a: residual term
        yx        = PROD_W'(in_y) * PROD_W'(in_x);
        two_minus = {1'b1, {PROD_W{1'b0}}} - {1'b0, yx};
        st_d.a_v  = in_valid;
        st_d.a_y  = in_y;
        st_d.a_x  = in_x;
        st_d.a_t  = FW'(two_minus >> YW);
        st_d.a_p  = in_pay;

        // stage b: scale the estimate
        xt        = MUL2_W'(st_q.a_x) * MUL2_W'(st_q.a_t);
        st_d.b_v  = st_q.a_v;
        st_d.b_y  = st_q.a_y;
        st_d.b_x  = FW'(xt >> (FW - 1));
        st_d.b_p  = st_q.a_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.b_v;
    assign out_y     = st_q.b_y;
    assign out_x     = st_q.b_x;
    assign out_pay   = st_q.b_p;

endmodule

// File: rtl/fp_recip_pipe.sv
module fp_recip_pipe #(
    parameter int NR_ITERS   = 2,
    parameter int SEED_IDX_W = 8,
    parameter int SEED_W     = 16,
    parameter int FRAC_W     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic [31:0] out_data
);
    import fp_recip_pkg::*;

    localparam int YW     = MAN_W + 1;
    localparam int PW     = $bits(opmeta_t);
    localparam int RND_SH = FRAC_W - YW;

    typedef struct packed {
        logic              s_v;
        logic [YW-1:0]     s_y;
        logic [FRAC_W-1:0] s_x;
        opmeta_t           s_m;
        logic              o_v;
        logic [FP_W-1:0]   o_d;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [EXP_W:0]      exp_ent;
    logic [SEED_W-1:0]   seed;
    logic [EXP_W-1:0]    in_exp;
    logic [MAN_W-1:0]    in_frac;

    logic                v_chain [NR_ITERS+1];
    logic [YW-1:0]       y_chain [NR_ITERS+1];
    logic [FRAC_W-1:0]   x_chain [NR_ITERS+1];
    logic [PW-1:0]       p_chain [NR_ITERS+1];

    opmeta_t             m_last;
    logic [FRAC_W:0]     rsum;
    logic [YW:0]         rq;

    assign in_exp  = in_data[FP_W-2 -: EXP_W];
    assign in_frac = in_data[MAN_W-1:0];

    fp_recip_exp_rom #(.EXP_W(EXP_W)) u_exp_rom (
        .idx   (in_data[FP_W-1 -: EXP_W+1]),
        .entry (exp_ent)
    );

    fp_recip_seed_rom #(.IDX_W(SEED_IDX_W), .SEED_W(SEED_W)) u_seed_rom (
        .idx  (in_frac[MAN_W-1 -: SEED_IDX_W]),
        .seed (seed)
    );

    assign v_chain[0] = st_q.s_v;
    assign y_chain[0] = st_q.s_y;
    assign x_chain[0] = st_q.s_x;
    assign p_chain[0] = st_q.s_m;

    for (genvar k = 0; k < NR_ITERS; k++) begin : g_nr
        fp_recip_nr_step #(.YW(YW), .FW(FRAC_W), .PW(PW)) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (v_chain[k]),
            .in_y      (y_chain[k]),
            .in_x      (x_chain[k]),
            .in_pay    (p_chain[k]),
            .out_valid (v_chain[k+1]),
            .out_y     (y_chain[k+1]),
            .out_x     (x_chain[k+1]),
            .out_pay   (p_chain[k+1])
        );
    end

    assign m_last = opmeta_t'(p_chain[NR_ITERS]);

    always_comb begin
        st_d = st_q;

        // decode stage: classify, look up scale and first guess
        st_d.s_v       = in_valid;
        st_d.s_y       = {1'b1, in_frac};
        st_d.s_x       = FRAC_W'(seed) << (FRAC_W - SEED_W);
        st_d.s_m.sign  = exp_ent[EXP_W];
        st_d.s_m.ebase = exp_ent[EXP_W-1:0];
        if (in_exp == '0) begin
            st_d.s_m.cls = CLS_ZERO;
        end else if (in_exp == '1) begin
            st_d.s_m.cls = (in_frac == '0) ? CLS_INF : CLS_NAN;
        end else begin
            st_d.s_m.cls = CLS_NORM;
        end

        // output stage: round to YW bits and recombine with the scale
        rsum = (FRAC_W + 1)'(x_chain[NR_ITERS]) + ((FRAC_W + 1)'(1) << (RND_SH - 1));
        rq   = (YW + 1)'(rsum >> RND_SH);

        st_d.o_v = v_chain[NR_ITERS];
        unique case (m_last.cls)
            CLS_NAN:  st_d.o_d = CANON_QNAN;
            CLS_ZERO: st_d.o_d = {m_last.sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            CLS_INF:  st_d.o_d = {m_last.sign, {(FP_W-1){1'b0}}};
            default: begin
                if (rq[YW]) begin
                    if (m_last.ebase == '0) begin
                        st_d.o_d = {m_last.sign, {(FP_W-1){1'b0}}};
                    end else begin
                        st_d.o_d = {m_last.sign, m_last.ebase, {MAN_W{1'b0}}};
                    end
                end else if (m_last.ebase <= EXP_W'(1)) begin
                    st_d.o_d = {m_last.sign, {(FP_W-1){1'b0}}};
                end else begin
                    st_d.o_d = {m_last.sign, m_last.ebase - EXP_W'(1), MAN_W'(rq)};
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_v;
    assign out_data  = st_q.o_d;

endmodule

// File: rtl/fp_recip_chk.sv
module fp_recip_chk #(
    parameter int NR_ITERS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [31:0] out_data
);
    localparam int LAT = 2 * NR_ITERS + 2;

    logic [LAT-1:0] v_sr;
    logic [31:0]    d_sr [LAT];
    logic [31:0]    d_old;
    logic           old_nan, old_inf, old_zero, old_norm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_sr <= '0;
            for (int i = 0; i < LAT; i++) d_sr[i] <= '0;
        end else begin
            v_sr    <= {v_sr[LAT-2:0], in_valid};
            d_sr[0] <= in_data;
            for (int i = 1; i < LAT; i++) d_sr[i] <= d_sr[i-1];
        end
    end

    assign d_old    = d_sr[LAT-1];
    assign old_zero = (d_old[30:23] == 8'h00);
    assign old_inf  = (d_old[30:23] == 8'hFF) && (d_old[22:0] == '0);
    assign old_nan  = (d_old[30:23] == 8'hFF) && (d_old[22:0] != '0);
    assign old_norm = !old_zero && (d_old[30:23] != 8'hFF);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_sr[LAT-1]);

    assert_nan_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && old_nan) |-> (out_data == 32'h7FC0_0000));

    assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && old_zero) |-> (out_data == {d_old[31], 8'hFF, 23'h0}));

    assert_inf_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && old_inf) |-> (out_data == {d_old[31], 31'h0}));

    assert_sign_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !old_nan) |-> (out_data[31] == d_old[31]));

    assert_finite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && old_norm) |-> (out_data[30:23] != 8'hFF));

    assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

endmodule

bind fp_recip_pipe fp_recip_chk #(.NR_ITERS(NR_ITERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_fp_recip_pipe.sv
module tb_fp_recip_pipe;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_data;
    logic        out_valid;
    logic [31:0] out_data;

    always #5 clk = ~clk;

    fp_recip_pipe dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        tol;
        logic [31:0] din;
        logic [31:0] dexp;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    fails  = 0;

    // {requirement, operand, exact result}
    localparam int NV = 20;
    localparam logic [71:0] VEC [NV] = '{
        72'h02_3F800000_3F800000,   // R2  1.0
        72'h02_40000000_3F000000,   // R2  2.0
        72'h02_3F000000_40000000,   // R2  0.5
        72'h03_C0800000_BE800000,   // R3  -4.0
        72'h02_41000000_3E000000,   // R2  8.0
        72'h03_BE000000_C1000000,   // R3  -0.125
        72'h02_00800000_7E800000,   // R2  smallest normal
        72'h02_7E800000_00800000,   // R2  result is smallest normal
        72'h07_7F000000_00000000,   // R7  2^127
        72'h07_FF000000_80000000,   // R7  -2^127
        72'h07_7EC00000_00000000,   // R7  exponent 253, fraction nonzero
        72'h07_FE800001_80000000,   // R7
        72'h04_00000000_7F800000,   // R4  +0
        72'h04_80000000_FF800000,   // R4  -0
        72'h04_00000001_7F800000,   // R4  denormal
        72'h04_807FFFFF_FF800000,   // R4  negative denormal
        72'h05_7F800000_00000000,   // R5  +inf
        72'h05_FF800000_80000000,   // R5  -inf
        72'h06_7FC00000_7FC00000,   // R6  quiet NaN
        72'h06_FF800001_7FC00000    // R6  signalling negative NaN
    };

    task automatic do_check(input int req, input logic ok,
                            input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, expv);
        end
    endtask

    // integer model of the correctly rounded reciprocal (R1, R2, R4-R7)
    function automatic logic [31:0] model(input logic [31:0] a);
        logic            s;
        int              e;
        int              ex;
        longint unsigned m;
        longint unsigned q;
        s = a[31];
        e = int'(a[30:23]);
        if (e == 0)   return {s, 8'hFF, 23'h0};
        if (e == 255) return (a[22:0] != '0) ? 32'h7FC00000 : {s, 31'h0};
        if (a[22:0] == '0) begin
            ex = 254 - e;
            if (ex <= 0) return {s, 31'h0};
            return {s, 8'(ex), 23'h0};
        end
        m  = (64'd1 << 23) | 64'(a[22:0]);
        q  = (((64'd1 << 48) / m) + 64'd1) >> 1;
        ex = 253 - e;
        if (ex <= 0) return {s, 31'h0};
        return {s, 8'(ex), 23'(q)};
    endfunction

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        item_t       it;
        logic        ok;
        logic [30:0] dif;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                do_check(9, 1'b0, out_data, 32'h0);   // R9 unexpected result
            end else begin
                it = exp_q.pop_front();
                if (it.tol) begin
                    dif = (out_data[30:0] >= it.dexp[30:0]) ? out_data[30:0] - it.dexp[30:0]
                                                            : it.dexp[30:0] - out_data[30:0];
                    ok  = (out_data[31] == it.dexp[31]) && (dif <= 31'd1);
                end else begin
                    ok = (out_data == it.dexp);
                end
                do_check(int'(it.req), ok, out_data, it.dexp);
            end
        end
    end

    task automatic send(input logic [31:0] d, input logic [31:0] e, input logic tol, input int req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        it.req   = 8'(req);
        it.tol   = tol;
        it.din   = d;
        it.dexp  = e;
        exp_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_model(input logic [31:0] a, input int req);
        logic [31:0] e;
        e = model(a);
        send(a, e, (e[30:0] != '0) && (a[30:23] != 8'h00) && (a[30:23] != 8'hFF), req);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rnd;
        int          lat;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;

        // R10: quiet during reset
        repeat (3) begin
            @(negedge clk);
            do_check(10, out_valid == 1'b0, 32'(out_valid), 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        do_check(10, out_valid == 1'b0, 32'(out_valid), 32'h0);

        // vector table, back to back (R2-R7, R9)
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][63:32], VEC[i][31:0], 1'b0, int'(VEC[i][71:64]));
        end
        idle(10);

        // R8: single operand, count cycles to its result
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h40000000;
        exp_q.push_back({8'd8, 1'b0, 32'h40000000, 32'h3F000000});
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        do_check(8, lat == 6, 32'(lat), 32'd6);
        @(negedge clk);
        do_check(8, out_valid == 1'b0, 32'(out_valid), 32'h0);
        idle(4);

        // R9: operands with idle gaps, mixed specials
        rnd = 32'h1234_5678;
        for (int i = 0; i < 24; i++) begin
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 17);
            rnd = rnd ^ (rnd << 5);
            if (i % 5 == 0) send_model({rnd[31], 8'hFF, rnd[22:0] | 23'h1}, 6);
            else if (i % 7 == 0) send_model({rnd[31], 8'h00, rnd[22:0]}, 4);
            else send_model({rnd[31], 8'(1 + int'(rnd[30:23]) % 254), rnd[22:0]}, 9);
            if (i % 3 == 0) idle(1 + i % 2);
        end
        idle(10);

        // R1/R7 mantissa extremes at exponent edges
        for (int ei = 0; ei < 7; ei++) begin
            for (int fi = 0; fi < 6; fi++) begin
                int          ev;
                logic [22:0] fv;
                ev = (ei == 0) ? 1 : (ei == 1) ? 126 : (ei == 2) ? 127 : (ei == 3) ? 252 :
                     (ei == 4) ? 253 : (ei == 5) ? 254 : 200;
                fv = (fi == 0) ? 23'h0 : (fi == 1) ? 23'h1 : (fi == 2) ? 23'h2 :
                     (fi == 3) ? 23'h7FFFFF : (fi == 4) ? 23'h7FFFFE : 23'h400000;
                send_model({fi[0], 8'(ev), fv}, 1);
            end
        end

        // R1 pseudo-random normal operands, back to back
        for (int i = 0; i < 3000; i++) begin
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 17);
            rnd = rnd ^ (rnd << 5);
            send_model({rnd[31], 8'(1 + int'(rnd[30:23]) % 254), rnd[22:0]}, 1);
        end
        idle(12);
        do_check(9, exp_q.size() == 0, 32'(exp_q.size()), 32'h0);   // R9 all delivered

        // R10: reset in mid-stream discards operands in flight
        send(32'h40800000, 32'h3E800000, 1'b0, 10);
        send(32'h40800000, 32'h3E800000, 1'b0, 10);
        send(32'h40800000, 32'h3E800000, 1'b0, 10);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        exp_q.delete();
        @(negedge clk);
        do_check(10, out_valid == 1'b0, 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        repeat (10) begin
            @(negedge clk);
            do_check(10, out_valid == 1'b0, 32'(out_valid), 32'h0);
        end

        finish_run();
    end

endmodule